// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a 32-bit timer of the kind found in a processor's system-control logic. A free-running count register advances once every second core clock, whatever the instruction pipeline is doing. A compare register holds a target value. When the count reaches that target, a level interrupt output goes high. The output stays high until software rewrites the compare register.

Software reaches the three registers through one simple port. The port has a write strobe, a two-bit register select, 32-bit write data and a combinational read-data output. A control register holds two bits. One stops counting altogether. The other decides whether counting goes on while the core's debug-mode input is high. Software normally programs the next deadline by writing compare, and that write also acknowledges the pending interrupt.

Top module: `cc_timer`

## Requirements
- R1: When counting is enabled, the count register increases by exactly one on every second clock and never changes by any other amount unless it is written. The enabled clocks follow each other in a fixed half-rate phase.
- R2: While control bit 0 (disable) is 1, the count and its half-rate phase hold their values.
- R3: A write with select 0 loads the count register with the write data on the next clock. The same write restarts the half-rate phase, so the first increment comes two enabled clocks after the load.
- R4: Control bit 1 (count-in-debug) sets what happens while the debug input is high. When it is 0, the count and its phase are frozen. When it is 1, counting goes on as normal.
- R5: The compare register changes only on a write with select 1. It reads back at select 1.
- R6: The interrupt output rises on the clock after a cycle in which the registered count equals compare. It then stays high for as long as compare is not written.
- R7: A compare write drives the interrupt output low on the next clock. This write wins over an equality match in the same cycle, and it does so even when the new value equals the count. If the equality still holds afterwards, the output rises again one clock later.
- R8: Reset values are: count 0, compare 0xFFFFFFFF, control bits 0, interrupt low.
- R9: The count wraps from 0xFFFFFFFF to 0.
- R10: The select values are 0 for count, 1 for compare, 2 for control and 3 for no register. Control reads return the disable bit at bit 0 and count-in-debug at bit 1, with every other bit 0. Writes with select 3 are ignored and reads with select 3 return 0. Read data follows the select in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode_i | input | 1 | Core is in debug mode |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select (0 count, 1 compare, 2 control, 3 none) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for the selected register |
| timer_irq_o | output | 1 | Level timer interrupt |

## Verification
The two functions that can meet in one cycle are the equality match that sets the interrupt and the compare write that clears it. The bench creates the collision by freezing the count with the disable bit, so that count and compare stay equal and the match is present on every cycle. It then writes compare with that same value. The reference model expects the output low on the next clock and high again one clock later. A randomized phase also mixes count writes, compare writes and debug toggles around live matches, and every clock is compared against the model.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
   typedef enum logic [1:0] {
      SEL_COUNT   = 2'd0,
      SEL_COMPARE = 2'd1,
      SEL_CTRL    = 2'd2,
      SEL_NONE    = 2'd3
   } cc_sel_e;

   localparam int CTL_DIS_BIT = 0;
   localparam int CTL_CID_BIT = 1;
endpackage

// File: rtl/cc_prescale.sv
module cc_prescale #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("cc_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_direct
         logic unused_sig;
         assign unused_sig = clr_i ^ rst_n;
         assign tick_o = en_i;
      end else begin : g_divided
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         phase_q <= '0;
            else if (clr_i)     phase_q <= '0;
            else if (en_i)      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
         end

         assign tick_o = en_i && (phase_q == LAST);

         AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_i && !clr_i) |=> $stable(phase_q)); // R2
         AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> (phase_q == '0)); // R3
      end
   endgenerate
endmodule

// File: rtl/cc_count.sv
module cc_count #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         tick_i,
   output logic [W-1:0] count_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("cc_count: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count_q <= '0;
      else if (wr_i)     count_q <= wdata_i;
      else if (tick_i)   count_q <= count_q + 1'b1;
   end

   assign count_o = count_q;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R1
   AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (count_q == $past(wdata_i))); // R3
endmodule

// File: rtl/cc_regs.sv
module cc_regs #(
   parameter int W = 32,
   parameter logic [W-1:0] CMP_RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_cmp_i,
   input  logic         wr_ctl_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] cmp_o,
   output logic         dis_o,
   output logic         cid_o
);
   import cc_timer_pkg::*;

   logic [W-1:0] cmp_q;
   logic         dis_q;
   logic         cid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cmp_q <= CMP_RST;
      else if (wr_cmp_i)   cmp_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= 1'b0;
         cid_q <= 1'b0;
      end else if (wr_ctl_i) begin
         dis_q <= wdata_i[CTL_DIS_BIT];
         cid_q <= wdata_i[CTL_CID_BIT];
      end
   end

   assign cmp_o = cmp_q;
   assign dis_o = dis_q;
   assign cid_o = cid_q;

   AST_CMP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cmp_i |=> $stable(cmp_q)); // R5
   AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl_i |=> ($stable(dis_q) && $stable(cid_q))); // R10
endmodule

// File: rtl/cc_irq_latch.sv
module cc_irq_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] count_i,
   input  logic [W-1:0] cmp_i,
   input  logic         clr_i,
   output logic         irq_o
);
   logic irq_q;
   logic hit;

   assign hit = (count_i == cmp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_q <= 1'b0;
      else if (clr_i)  irq_q <= 1'b0;
      else if (hit)    irq_q <= 1'b1;
   end

   assign irq_o = irq_q;

   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !irq_q); // R7
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_i) |=> irq_q); // R6
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr_i) |=> irq_q); // R6
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(hit)); // R6
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
   parameter int W = 32,
   parameter int DIV = 2,
   parameter logic [W-1:0] CMP_RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dbg_mode_i,
   input  logic         wr_en_i,
   input  logic [1:0]   sel_i,
   input  logic [31:0]  wdata_i,
   output logic [31:0]  rdata_o,
   output logic         timer_irq_o
);
   import cc_timer_pkg::*;

   generate
      if (W != 32) begin : g_bad_w
         $error("cc_timer: port data width is fixed at 32");
      end
   endgenerate

   cc_sel_e sel;
   logic    wr_cnt, wr_cmp, wr_ctl;
   logic    dis, cid, run, tick;
   logic [W-1:0] count, cmp;

   assign sel    = cc_sel_e'(sel_i);
   assign wr_cnt = wr_en_i && (sel == SEL_COUNT);
   assign wr_cmp = wr_en_i && (sel == SEL_COMPARE);
   assign wr_ctl = wr_en_i && (sel == SEL_CTRL);

   cc_regs #(.W(W), .CMP_RST(CMP_RST)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmp_i (wr_cmp),
      .wr_ctl_i (wr_ctl),
      .wdata_i  (wdata_i),
      .cmp_o    (cmp),
      .dis_o    (dis),
      .cid_o    (cid)
   );

   assign run = !dis && (!dbg_mode_i || cid);

   cc_prescale #(.DIV(DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (wr_cnt),
      .en_i   (run),
      .tick_o (tick)
   );

   cc_count #(.W(W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_cnt),
      .wdata_i (wdata_i),
      .tick_i  (tick && !wr_cnt),
      .count_o (count)
   );

   cc_irq_latch #(.W(W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (count),
      .cmp_i   (cmp),
      .clr_i   (wr_cmp),
      .irq_o   (timer_irq_o)
   );

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_COUNT:   rdata_o = count;
         SEL_COMPARE: rdata_o = cmp;
         SEL_CTRL: begin
            rdata_o[CTL_DIS_BIT] = dis;
            rdata_o[CTL_CID_BIT] = cid;
         end
         default:     rdata_o = '0;
      endcase
   end

   AST_DISABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dis && !wr_cnt) |=> $stable(count)); // R2
   AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_mode_i && !cid && !wr_cnt) |=> $stable(count)); // R4
   AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_cnt) |=> !tick); // R1
   AST_NONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (rdata_o == '0)); // R10
endmodule

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_mode_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  sel_i = 2'd0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        timer_irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic [31:0] m_cnt, m_cmp;
   logic        m_dis, m_cid, m_ph, m_irq;

   always #5 clk = ~clk;

   cc_timer u_cc_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .dbg_mode_i  (dbg_mode_i),
      .wr_en_i     (wr_en_i),
      .sel_i       (sel_i),
      .wdata_i     (wdata_i),
      .rdata_o     (rdata_o),
      .timer_irq_o (timer_irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " irq"}, {31'b0, timer_irq_o}, {31'b0, m_irq});
      wr_en_i = 1'b0;
      sel_i = 2'd0; #1; chk({tag, " count"}, rdata_o, m_cnt);
      sel_i = 2'd1; #1; chk({tag, " compare"}, rdata_o, m_cmp);
      sel_i = 2'd2; #1; chk({tag, " control"}, rdata_o, {30'b0, m_cid, m_dis});
      sel_i = 2'd3; #1; chk({tag, " none"}, rdata_o, 32'h0);
   endtask

   task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                       input logic dbg, input string tag);
      logic [31:0] n_cnt, n_cmp;
      logic n_dis, n_cid, n_ph, n_irq, en;
      wr_en_i = we; sel_i = sel; wdata_i = d; dbg_mode_i = dbg;
      en = !m_dis && (!dbg || m_cid);
      n_cnt = m_cnt; n_cmp = m_cmp; n_dis = m_dis; n_cid = m_cid; n_ph = m_ph;
      if (we && sel == 2'd1) n_irq = 1'b0;
      else if (m_cnt == m_cmp) n_irq = 1'b1;
      else n_irq = m_irq;
      if (we && sel == 2'd0) begin
         n_cnt = d; n_ph = 1'b0;
      end else if (en) begin
         if (m_ph) n_cnt = m_cnt + 32'd1;
         n_ph = ~m_ph;
      end
      if (we && sel == 2'd1) n_cmp = d;
      if (we && sel == 2'd2) begin n_dis = d[0]; n_cid = d[1]; end
      @(posedge clk);
      @(negedge clk);
      m_cnt = n_cnt; m_cmp = n_cmp; m_dis = n_dis; m_cid = n_cid; m_ph = n_ph; m_irq = n_irq;
      check_all(tag);
   endtask

   task automatic idle(input int n, input logic dbg, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'h0, dbg, tag);
   endtask

   initial begin
      m_cnt = 0; m_cmp = 32'hFFFF_FFFF; m_dis = 0; m_cid = 0; m_ph = 0; m_irq = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R8 reset");

      // R1 free running at half rate
      idle(20, 1'b0, "R1 free run");

      // R3 count load restarts phase
      step(1'b0, 2'd0, 0, 1'b0, "R3 pre");
      step(1'b1, 2'd0, 32'h0000_1000, 1'b0, "R3 load");
      idle(5, 1'b0, "R3 after load");

      // R6 match and stickiness
      step(1'b1, 2'd1, m_cnt + 32'd4, 1'b0, "R5 compare write");
      idle(20, 1'b0, "R6 sticky");

      // R7 compare write clears
      step(1'b1, 2'd1, 32'h0000_9000, 1'b0, "R7 clear");
      idle(4, 1'b0, "R7 stays low");

      // R2 disable holds, then match/write collision
      step(1'b1, 2'd2, 32'h1, 1'b0, "R2 disable");
      idle(6, 1'b0, "R2 held");
      step(1'b1, 2'd1, m_cnt, 1'b0, "R7 equal compare");
      idle(3, 1'b0, "R7 reassert");
      step(1'b1, 2'd1, m_cnt, 1'b0, "R7 collision write");
      idle(3, 1'b0, "R7 collision after");
      step(1'b1, 2'd2, 32'h0, 1'b0, "R2 enable");
      idle(6, 1'b0, "R2 running");

      // R4 debug freeze and count-in-debug
      idle(8, 1'b1, "R4 frozen");
      step(1'b1, 2'd2, 32'h2, 1'b1, "R4 set cid");
      idle(8, 1'b1, "R4 debug counting");
      step(1'b1, 2'd2, 32'h0, 1'b0, "R4 clear cid");

      // R9 wrap
      step(1'b1, 2'd0, 32'hFFFF_FFFE, 1'b0, "R9 load");
      idle(8, 1'b0, "R9 wrap");

      // R10 select 3 ignored
      step(1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0, "R10 none write");
      idle(2, 1'b0, "R10 after none");

      // randomized mix with frequent matches
      for (int i = 0; i < 1500; i++) begin
         int r;
         logic [31:0] d;
         r = $urandom_range(0, 15);
         d = m_cnt + 32'($urandom_range(0, 6));
         if (r == 0)      step(1'b1, 2'd0, d, $urandom_range(0, 1) == 1, "R3 random");
         else if (r < 3)  step(1'b1, 2'd1, d, $urandom_range(0, 1) == 1, "R7 random");
         else if (r == 3) step(1'b1, 2'd2, 32'($urandom_range(0, 3)), $urandom_range(0, 1) == 1, "R4 random");
         else if (r == 4) step(1'b1, 2'd3, $urandom, 1'b0, "R10 random");
         else             step(1'b0, 2'd0, 0, $urandom_range(0, 3) == 0, "R1 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule